// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This controller sits beside the execution pipeline of a small 8-bit core and handles the steps the core takes when it enters interrupt service and when it leaves it. It watches a level-sensitive maskable request, an active-low non-maskable pin and a return-from-interrupt decode. At each instruction boundary it either does nothing, enters service or returns. To enter, it loads the program counter from a vector and pushes the interrupted PC onto a hardware stack. To return, it pops the saved PC and reloads the program counter with it.

Carry and zero flags are held in three independent banks, one for each operating mode: main, interrupt and non-maskable. The bank that drives the flag outputs and takes flag writes follows the current mode. Entry and return switch banks automatically, so service routines never save the flags in software. A non-maskable request may pre-empt a maskable routine that is already running. A maskable request that arrives during non-maskable service waits until it is unmasked again.

The state machine has three states. `ST_RUN` is normal execution, where requests are evaluated at boundaries. `ST_TAKE` is the entry cycle: PC load from the vector plus a stack push. `ST_BACK` is the return cycle: PC load from the stack top plus a pop. The transitions are: RUN to TAKE on an accepted request; RUN to BACK on a return decode; TAKE to RUN and BACK to RUN unconditionally; RUN to RUN otherwise.

Top module: `irq_seq`

## Requirements
- R1: After reset the mode output is 0 (main) and the mask is clear. pc_load, stk_push and stk_pop are low, and both flag outputs read 0 in every bank.
- R2: A high-to-low transition seen on nmi_n between two rising clock edges records a pending non-maskable request. A rising edge or a steady level records nothing. A pending request is removed only by entering non-maskable service.
- R3: At a boundary without a return decode, a pending non-maskable request in any mode other than 2 wins over everything else. In the next cycle pc_load is high, pc_tgt equals NMI_VEC (0xFFC by default) and stk_push is high. The PC presented on pc_cur at the boundary is pushed. The mode becomes 2 and the mask is set.
- R4: At a boundary with no return decode and no accepted non-maskable request, irq_req high with the mask clear is accepted. In the next cycle pc_load is high, pc_tgt equals IRQ_VEC (0xFF8 by default) and pc_cur is pushed. The mode becomes 1 (interrupt) and the mask is set.
- R5: While the mask is set, irq_req produces no action. The request is honoured at the first boundary after a return has cleared the mask, including after non-maskable service that began from main mode.
- R6: Requests and return decodes are acted upon only in a cycle where instr_done is high in ST_RUN. In every other cycle pc_load stays low.
- R7: A return decode at a boundary takes priority over any request. In the next cycle pc_load and stk_pop are high and pc_tgt equals the top stack level.
- R8: A return moves the mode as follows. From 1 it goes to 0 and clears the mask. From 2 it goes back to the mode that was active at entry, and clears the mask only when that mode is 0. From 0 it stays at 0, so only the pop happens.
- R9: With flag_we high, c_in and z_in are written into the bank of the current mode at the clock edge. c_out and z_out always show the bank of the current mode. The other banks keep their contents.
- R10: The stack holds STK_DEPTH levels. A push places the new PC on top. A pop moves every level up one place and fills the deepest level with 0, so popping an empty stack yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_n | input | 1 | Non-maskable request pin, falling edge records a request |
| irq_req | input | 1 | Maskable request, level sensitive |
| instr_done | input | 1 | Instruction boundary strobe |
| reti | input | 1 | Return-from-interrupt decode, qualified by instr_done |
| pc_cur | input | PC_W | PC to save on entry |
| flag_we | input | 1 | Write c_in and z_in into the active bank |
| c_in | input | 1 | Carry value to write |
| z_in | input | 1 | Zero value to write |
| pc_load | output | 1 | Load the program counter from pc_tgt |
| pc_tgt | output | PC_W | Vector on entry, popped PC on return |
| stk_push | output | 1 | Stack push in this cycle |
| stk_pop | output | 1 | Stack pop in this cycle |
| c_out | output | 1 | Carry of the active bank |
| z_out | output | 1 | Zero of the active bank |
| mode | output | 2 | 0 main, 1 interrupt, 2 non-maskable |
| mask | output | 1 | Maskable requests blocked |

## Verification
The bench builds the block with STK_DEPTH set to 3 and the default 12-bit PC and vectors. At this depth, returns issued from main mode quickly drain the stack into the zero-filled region. A long pseudo-random stream of boundaries, returns, pin toggles, request levels and flag writes is compared cycle by cycle against an arithmetic reference model. Within a few thousand operations this stream covers every mode pairing for entry and return: non-maskable pre-emption of interrupt service, masked requests waiting out non-maskable service, and empty pops. Directed sequences before the sweep pin down the priority orderings and bank independence.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        MODE_MAIN = 2'd0,
        MODE_INT  = 2'd1,
        MODE_NMI  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_TAKE = 2'd1,
        ST_BACK = 2'd2
    } state_e;

    typedef struct packed {
        logic c;
        logic z;
    } flags_t;

    localparam int NUM_MODES = 3;

endpackage

// File: rtl/irq_flag_banks.sv
module irq_flag_banks
    import irq_seq_pkg::*;
#(
    parameter int NBANK = NUM_MODES
) (
    input  logic   clk,
    input  logic   rst_n,
    input  mode_e  sel,
    input  logic   we,
    input  flags_t wr,
    output flags_t rd
);
    localparam int SEL_W = $clog2(NBANK);

    flags_t [NBANK-1:0] bank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            for (int b = 0; b < NBANK; b++) begin
                if (we && (SEL_W'(sel) == SEL_W'(b))) begin
                    bank_q[b] <= wr;
                end
            end
        end
    end

    always_comb begin
        rd = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (SEL_W'(sel) == SEL_W'(b)) begin
                rd = bank_q[b];
            end
        end
    end

    // R9
    banks_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(bank_q));

endmodule

// File: rtl/irq_hw_stack.sv
module irq_hw_stack #(
    parameter int DEPTH = 6,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);
    logic [DEPTH-1:0][W-1:0] lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (push) begin
            lvl_q <= {lvl_q[DEPTH-2:0], din};
        end else if (pop) begin
            lvl_q <= {W'(0), lvl_q[DEPTH-1:1]};
        end
    end

    assign top = lvl_q[0];

    // R10
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (top == $past(din)));

    // R10
    pop_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (top == $past(lvl_q[1])));

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int              PC_W      = 12,
    parameter int              STK_DEPTH = 6,
    parameter logic [PC_W-1:0] NMI_VEC   = 12'hFFC,
    parameter logic [PC_W-1:0] IRQ_VEC   = 12'hFF8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nmi_n,
    input  logic            irq_req,
    input  logic            instr_done,
    input  logic            reti,
    input  logic [PC_W-1:0] pc_cur,
    input  logic            flag_we,
    input  logic            c_in,
    input  logic            z_in,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_tgt,
    output logic            stk_push,
    output logic            stk_pop,
    output logic            c_out,
    output logic            z_out,
    output logic [1:0]      mode,
    output logic            mask
);
    state_e          state_q, state_d;
    mode_e           mode_q;
    logic            mask_q, from_int_q;
    logic            nmi_prev_q, nmi_pend_q;
    logic [PC_W-1:0] ret_pc_q, vec_q, stk_top;
    flags_t          flags_rd;

    logic at_bound, do_ret, do_nmi, do_irq;

    assign at_bound = (state_q == ST_RUN) && instr_done;
    assign do_ret   = at_bound && reti;
    assign do_nmi   = at_bound && !reti && nmi_pend_q && (mode_q != MODE_NMI);
    assign do_irq   = at_bound && !reti && !do_nmi && irq_req && !mask_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (do_ret)               state_d = ST_BACK;
                else if (do_nmi || do_irq) state_d = ST_TAKE;
            end
            ST_TAKE: state_d = ST_RUN;
            ST_BACK: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // mode, mask and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_MAIN;
            mask_q     <= 1'b0;
            from_int_q <= 1'b0;
            nmi_prev_q <= 1'b1;
            nmi_pend_q <= 1'b0;
            ret_pc_q   <= '0;
            vec_q      <= '0;
        end else begin
            nmi_prev_q <= nmi_n;
            nmi_pend_q <= (nmi_prev_q && !nmi_n) || (nmi_pend_q && !do_nmi);
            if (do_ret) begin
                unique case (mode_q)
                    MODE_INT: begin
                        mode_q <= MODE_MAIN;
                        mask_q <= 1'b0;
                    end
                    MODE_NMI: begin
                        mode_q <= from_int_q ? MODE_INT : MODE_MAIN;
                        mask_q <= from_int_q;
                    end
                    default: mode_q <= MODE_MAIN;
                endcase
            end else if (do_nmi) begin
                from_int_q <= (mode_q == MODE_INT);
                mode_q     <= MODE_NMI;
                mask_q     <= 1'b1;
                ret_pc_q   <= pc_cur;
                vec_q      <= NMI_VEC;
            end else if (do_irq) begin
                mode_q   <= MODE_INT;
                mask_q   <= 1'b1;
                ret_pc_q <= pc_cur;
                vec_q    <= IRQ_VEC;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        pc_load  = 1'b0;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        pc_tgt   = '0;
        unique case (state_q)
            ST_TAKE: begin
                pc_load  = 1'b1;
                stk_push = 1'b1;
                pc_tgt   = vec_q;
            end
            ST_BACK: begin
                pc_load = 1'b1;
                stk_pop = 1'b1;
                pc_tgt  = stk_top;
            end
            default: ;
        endcase
    end

    assign mode  = mode_q;
    assign mask  = mask_q;
    assign c_out = flags_rd.c;
    assign z_out = flags_rd.z;

    irq_flag_banks #(.NBANK(NUM_MODES)) u_banks (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (mode_q),
        .we    (flag_we),
        .wr    ('{c: c_in, z: z_in}),
        .rd    (flags_rd)
    );

    irq_hw_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   (ret_pc_q),
        .top   (stk_top)
    );

    // R2
    nmi_pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend_q && !do_nmi) |=> nmi_pend_q);

    // R3
    nmi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_bound && !reti && nmi_pend_q && mode_q != MODE_NMI)
        |=> (mode_q == MODE_NMI && pc_tgt == NMI_VEC && stk_push));

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_bound && !reti && mask_q && !(nmi_pend_q && mode_q != MODE_NMI))
        |=> !pc_load);

    // R6
    no_bound_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !instr_done) |=> !pc_load);

    // R7
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_push && stk_pop));

    // R8
    int_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ret && mode_q == MODE_INT) |=> (mode_q == MODE_MAIN && !mask_q));

endmodule

// File: tb/test_irq_seq.sv
`timescale 1ns/1ps
module test_irq_seq;
    localparam int PC_W  = 12;
    localparam int DEPTH = 3;
    localparam int NVEC  = 12'hFFC;
    localparam int IVEC  = 12'hFF8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic            rst_n, nmi_n, irq_req, instr_done, reti, flag_we, c_in, z_in;
    logic [PC_W-1:0] pc_cur, pc_tgt;
    logic            pc_load, stk_push, stk_pop, c_out, z_out, mask;
    logic [1:0]      mode;

    irq_seq #(.PC_W(PC_W), .STK_DEPTH(DEPTH)) i_irq_seq (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_req(irq_req),
        .instr_done(instr_done), .reti(reti), .pc_cur(pc_cur),
        .flag_we(flag_we), .c_in(c_in), .z_in(z_in),
        .pc_load(pc_load), .pc_tgt(pc_tgt), .stk_push(stk_push),
        .stk_pop(stk_pop), .c_out(c_out), .z_out(z_out),
        .mode(mode), .mask(mask)
    );

    int errs = 0;
    int checks = 0;

    // reference model
    int m_mode, m_mask, m_from_int, m_pend, m_prev;
    int m_stk [DEPTH];
    int m_c [3];
    int m_z [3];

    task automatic chk(string rq, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_mask = 0; m_from_int = 0; m_pend = 0; m_prev = 1;
        for (int i = 0; i < DEPTH; i++) m_stk[i] = 0;
        for (int i = 0; i < 3; i++) begin m_c[i] = 0; m_z[i] = 0; end
    endtask

    // one boundary-or-idle cycle, plus the action cycle if one is expected
    task automatic op(input logic d, input logic r, input logic irq, input logic pin,
                      input logic fwe, input logic c, input logic z, input int pc,
                      input string tag);
        int act;   // 0 none, 1 nmi, 2 irq, 3 return
        int tgt;
        @(negedge clk);
        chk("R8", "mode", int'(mode), m_mode);
        chk("R8", "mask", int'(mask), m_mask);
        chk("R9", "carry", int'(c_out), m_c[m_mode]);
        chk("R9", "zero", int'(z_out), m_z[m_mode]);
        chk("R6", "idle pc_load", int'(pc_load), 0);
        instr_done = d; reti = r; irq_req = irq; nmi_n = pin;
        flag_we = fwe; c_in = c; z_in = z; pc_cur = PC_W'(pc);
        act = 0;
        if (d && r) act = 3;
        else if (d && m_pend != 0 && m_mode != 2) act = 1;
        else if (d && irq && m_mask == 0) act = 2;
        tgt = (act == 1) ? NVEC : (act == 2) ? IVEC : m_stk[0];
        @(posedge clk);
        #1;
        instr_done = 1'b0; reti = 1'b0; flag_we = 1'b0;
        if (fwe) begin m_c[m_mode] = c; m_z[m_mode] = z; end
        m_pend = ((m_prev == 1 && pin == 0) || (m_pend != 0 && act != 1)) ? 1 : 0;
        m_prev = pin;
        if (act == 3) begin
            if (m_mode == 1) begin m_mode = 0; m_mask = 0; end
            else if (m_mode == 2) begin
                m_mode = m_from_int ? 1 : 0; m_mask = m_from_int;
            end
        end else if (act == 1) begin
            m_from_int = (m_mode == 1); m_mode = 2; m_mask = 1;
        end else if (act == 2) begin
            m_mode = 1; m_mask = 1;
        end
        if (act != 0) begin
            string t;
            t = (tag != "") ? tag : (act == 1) ? "R3" : (act == 2) ? "R4" : "R7";
            @(negedge clk);
            chk(t, "pc_load", int'(pc_load), 1);
            chk(t, "pc_tgt", int'(pc_tgt), tgt);
            chk("R10", "push", int'(stk_push), (act != 3) ? 1 : 0);
            chk("R10", "pop", int'(stk_pop), (act == 3) ? 1 : 0);
            @(posedge clk);
            #1;
            if (act == 3) begin
                for (int i = 0; i < DEPTH - 1; i++) m_stk[i] = m_stk[i+1];
                m_stk[DEPTH-1] = 0;
            end else begin
                for (int i = DEPTH - 1; i > 0; i--) m_stk[i] = m_stk[i-1];
                m_stk[0] = pc;
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        logic        pin;
        rst_n = 1'b0; nmi_n = 1'b1; irq_req = 1'b0; instr_done = 1'b0; reti = 1'b0;
        flag_we = 1'b0; c_in = 1'b0; z_in = 1'b0; pc_cur = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "mode", int'(mode), 0);
        chk("R1", "mask", int'(mask), 0);
        chk("R1", "pc_load", int'(pc_load), 0);
        chk("R1", "push", int'(stk_push), 0);
        chk("R1", "pop", int'(stk_pop), 0);
        chk("R1", "carry", int'(c_out), 0);
        chk("R1", "zero", int'(z_out), 0);

        // R10 pop of empty stack in main mode, R8 mode stays 0
        op(1, 1, 0, 1, 0, 0, 0, 12'h000, "R10");
        // R9 write main bank
        op(0, 0, 0, 1, 1, 1, 0, 12'h000, "");
        // R4 maskable entry
        op(1, 0, 1, 1, 0, 0, 0, 12'h123, "R4");
        op(0, 0, 0, 1, 1, 0, 1, 12'h000, "");
        // R5 masked request ignored
        op(1, 0, 1, 1, 0, 0, 0, 12'h200, "R5");
        // R2 fall, then rise and idle cycles, then boundary
        op(0, 0, 0, 0, 0, 0, 0, 12'h000, "");
        op(0, 0, 0, 1, 0, 0, 0, 12'h000, "");
        op(0, 0, 0, 1, 0, 0, 0, 12'h000, "");
        op(1, 0, 0, 1, 0, 0, 0, 12'h456, "R2");
        // R5 during non-maskable service
        op(1, 0, 1, 1, 0, 0, 0, 12'h300, "R5");
        // R8 returns back through interrupt to main
        op(1, 1, 0, 1, 0, 0, 0, 12'h000, "R8");
        op(1, 1, 0, 1, 0, 0, 0, 12'h000, "R8");
        // R3 priority over maskable from main, then R5 pending irq after return
        op(0, 0, 0, 0, 0, 0, 0, 12'h000, "");
        op(1, 0, 1, 0, 0, 0, 0, 12'h777, "R3");
        op(1, 1, 1, 1, 0, 0, 0, 12'h000, "R7");
        op(1, 0, 1, 1, 0, 0, 0, 12'h888, "R5");
        op(1, 1, 0, 1, 0, 0, 0, 12'h000, "R7");

        // pseudo-random sweep against the model
        lf  = 16'hACE1;
        pin = 1'b1;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[5] && lf[6]) pin = ~pin;
            op(lf[0] | lf[1], lf[2] & lf[3], lf[4], pin, lf[7], lf[8], lf[9],
               int'(lf[11:0]), "");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule